// File: doc/BRIEF.md
# SPI Serial Memory Command Slave

This block is the command front end of a byte-wide serial memory. A bus master selects it with an active-low chip select and shifts one command byte. Depending on that command, the master then sends a two-byte address followed by a stream of data bytes, or sends or receives a single status byte. The slave works in SPI modes 0 and 3. It samples the input line on rising serial-clock edges and changes its output on falling edges, most significant bit first.

All logic runs on a fast system clock. The serial clock, chip select, data input and pause input are passed through synchronisers, and their edges are detected. The storage array sits outside the block behind a synchronous port with one cycle of read latency. Each byte is committed as soon as its eighth bit arrives, and no page buffer is used. A separate write-protection unit owns the write latch and the status contents. The slave sends it strobes, shows it the address that is currently active, and reads back two permission bits: one for memory writes and one for status writes.

Top module: `spi_mem_slave`

## Requirements
- R1: Only the first byte after chip select falls is decoded as a command: 06h latch set, 04h latch clear, 05h status read, 01h status write, 03h memory read, 02h memory write. Any other first byte, and every later byte, issues no strobe, no memory access and no output drive until chip select rises.
- R2: Bytes travel MSB first. `si` is sampled on rising `sck` edges, and `so` changes only after falling `sck` edges, never while `sck` stays high.
- R3: Memory commands take a high address byte and then a low address byte. Bits 7..5 of the high byte are ignored, which leaves a 13-bit address.
- R4: A memory read drives the byte at the address on the eight clocks that follow the address, with `si` ignored. It then continues with the following addresses and wraps from 1FFFh to 0000h.
- R5: During a memory write, each complete data byte gives one `mem_we` pulse with `mem_addr` set to the byte's address, but only when `wp_mem_ok` is high while `wp_chk_addr` shows that address. The address then advances and wraps from 1FFFh to 0000h.
- R6: Command 06h gives one `wp_latch_set` pulse when the command byte completes. Commands 04h, 01h and 02h each give one `wp_latch_clr` pulse after chip select rises.
- R7: Command 05h shifts out the `wp_status` byte once, then releases `so_oe`.
- R8: Command 01h takes one byte and pulses `wp_stat_wr` with that byte on `wp_stat_wdata` only if `wp_stat_ok` is high. Later bytes are ignored.
- R9: A rising chip select ends any command and discards a partial byte. `so_oe` is low whenever no read data is being driven.
- R10: While `hold_n` is low, `sck` edges are ignored and `so_oe` is low. When `hold_n` returns high, the transfer resumes where it stopped.
- R11: After reset, `so_oe`, `mem_we`, `mem_re` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| mem_addr | output | 13 | Memory port address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after mem_re |
| wp_chk_addr | output | 13 | Address of the byte in progress, for the protection unit |
| wp_mem_ok | input | 1 | Protection unit allows a write at wp_chk_addr |
| wp_stat_ok | input | 1 | Protection unit allows a status write |
| wp_status | input | 8 | Status byte returned by command 05h |
| wp_latch_set | output | 1 | Write-latch set strobe |
| wp_latch_clr | output | 1 | Write-latch clear strobe |
| wp_stat_wr | output | 1 | Status write strobe |
| wp_stat_wdata | output | 8 | Status write data |

## Verification
A data byte committed at the top address and the wrap of the address counter to zero happen in the same cycle. The bench provokes this by starting writes and reads at 1FFEh, so that a single transfer crosses the boundary. The result is judged from the memory contents at 1FFEh, 1FFFh, 0000h and 0001h, from the untouched byte at 0002h, and from the read stream that comes back over the boundary. Randomised writes and read-backs with random protection limits check the same path at arbitrary addresses.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_OPC, PH_ADH, PH_ADL, PH_WDAT, PH_RDAT, PH_SWR, PH_SRD, PH_SKIP
  } phase_t;

  localparam logic [7:0] OP_LSET = 8'h06;
  localparam logic [7:0] OP_LCLR = 8'h04;
  localparam logic [7:0] OP_SRD  = 8'h05;
  localparam logic [7:0] OP_SWR  = 8'h01;
  localparam logic [7:0] OP_MRD  = 8'h03;
  localparam logic [7:0] OP_MWR  = 8'h02;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         en,
  input  logic         hold_ok,
  output logic         so,
  output logic         so_oe
);
  logic [W-1:0] sr;
  logic         live;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      so    <= 1'b0;
      live  <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      if (load)
        sr <= din;
      else if (shift && en)
        sr <= {sr[W-2:0], 1'b0};
      if (shift && en)
        so <= sr[W-1];
      live  <= en & (live | shift);
      so_oe <= en & hold_ok & (live | shift);
    end
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int AW = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic          hold_n,
  output logic          so,
  output logic          so_oe,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] wp_chk_addr,
  input  logic          wp_mem_ok,
  input  logic          wp_stat_ok,
  input  logic [7:0]    wp_status,
  output logic          wp_latch_set,
  output logic          wp_latch_clr,
  output logic          wp_stat_wr,
  output logic [7:0]    wp_stat_wdata
);
  localparam int HI_W = AW - 8;

  logic [3:0] syn;
  logic sck_s, cs_s, si_s, hold_s;
  logic sck_q, cs_q;

  spi_in_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) i_sync (
    .clk(clk), .rst(rst), .d({sck, cs_n, si, hold_n}), .q(syn)
  );
  assign {sck_s, cs_s, si_s, hold_s} = syn;

  phase_t        phase;
  logic [2:0]    bitcnt;
  logic [6:0]    rx_sr;
  logic [AW-1:0] addr;
  logic          ld_q, stat_ld, clr_pend;

  wire cs_fall  = ~cs_s & cs_q;
  wire cs_rise  = cs_s & ~cs_q;
  wire sck_rise = sck_s & ~sck_q & hold_s & ~cs_s;
  wire sck_fall = ~sck_s & sck_q & hold_s & ~cs_s;
  wire [7:0] byte_in = {rx_sr, si_s};
  wire rd_phase = (phase == PH_RDAT) || (phase == PH_SRD);

  assign wp_chk_addr = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0; cs_q <= 1'b1;
      phase <= PH_IDLE; bitcnt <= '0; rx_sr <= '0; addr <= '0;
      mem_addr <= '0; mem_we <= 1'b0; mem_re <= 1'b0; mem_wdata <= '0;
      ld_q <= 1'b0; stat_ld <= 1'b0; clr_pend <= 1'b0;
      wp_latch_set <= 1'b0; wp_latch_clr <= 1'b0;
      wp_stat_wr <= 1'b0; wp_stat_wdata <= '0;
    end else begin
      sck_q <= sck_s; cs_q <= cs_s;
      mem_we <= 1'b0; mem_re <= 1'b0; ld_q <= mem_re; stat_ld <= 1'b0;
      wp_latch_set <= 1'b0; wp_latch_clr <= 1'b0; wp_stat_wr <= 1'b0;
      if (cs_rise) begin
        phase <= PH_IDLE; bitcnt <= '0;
        wp_latch_clr <= clr_pend; clr_pend <= 1'b0;
      end else if (cs_fall) begin
        phase <= PH_OPC; bitcnt <= '0; clr_pend <= 1'b0;
      end else if (sck_rise && phase != PH_IDLE) begin
        rx_sr  <= byte_in[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          unique case (phase)
            PH_OPC: begin
              phase <= PH_SKIP;
              unique case (byte_in)
                OP_LSET: wp_latch_set <= 1'b1;
                OP_LCLR: clr_pend <= 1'b1;
                OP_SRD:  begin stat_ld <= 1'b1; phase <= PH_SRD; end
                OP_SWR:  begin clr_pend <= 1'b1; phase <= PH_SWR; end
                OP_MRD:  phase <= PH_ADH;
                OP_MWR:  begin clr_pend <= 1'b1; phase <= PH_ADH; end
                default: phase <= PH_SKIP;
              endcase
            end
            PH_ADH: begin
              addr[AW-1:8] <= byte_in[HI_W-1:0];
              phase <= PH_ADL;
            end
            PH_ADL: begin
              addr[7:0] <= byte_in;
              if (clr_pend) phase <= PH_WDAT;
              else begin
                phase <= PH_RDAT;
                mem_addr <= {addr[AW-1:8], byte_in};
                mem_re <= 1'b1;
              end
            end
            PH_WDAT: begin
              mem_addr  <= addr;
              mem_wdata <= byte_in;
              mem_we    <= wp_mem_ok;
              addr      <= addr + AW'(1);
            end
            PH_RDAT: begin
              addr     <= addr + AW'(1);
              mem_addr <= addr + AW'(1);
              mem_re   <= 1'b1;
            end
            PH_SWR: begin
              wp_stat_wr    <= wp_stat_ok;
              wp_stat_wdata <= byte_in;
              phase         <= PH_SKIP;
            end
            PH_SRD:  phase <= PH_SKIP;
            default: phase <= phase;
          endcase
        end
      end
    end
  end

  spi_tx_shift #(.W(8)) i_tx (
    .clk(clk), .rst(rst),
    .load(ld_q | stat_ld), .din(stat_ld ? wp_status : mem_rdata),
    .shift(sck_fall), .en(rd_phase & ~cs_s), .hold_ok(hold_s),
    .so(so), .so_oe(so_oe)
  );

  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)); // R5
  AST_WE_GRANTED: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(wp_mem_ok)); // R5
  AST_STAT_GRANTED: assert property (@(posedge clk) disable iff (rst)
    wp_stat_wr |-> $past(wp_stat_ok)); // R8
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wp_latch_set && wp_latch_clr)); // R6
  AST_OE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> ($past(hold_s) && !$past(cs_s))); // R9
  AST_SO_HIGH_STABLE: assert property (@(posedge clk) disable iff (rst)
    (sck_s && sck_q) |=> $stable(so)); // R2
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!hold_s && !cs_s && !cs_q) |=> $stable(bitcnt)); // R10
endmodule

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 6 * CLK_P;
  localparam int AW    = 13;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, mem_we, mem_re, wp_mem_ok, wp_latch_set, wp_latch_clr, wp_stat_wr;
  logic wp_stat_ok = 1'b1;
  logic [7:0] wp_status = 8'h8C;
  logic [AW-1:0] mem_addr, wp_chk_addr;
  logic [7:0] mem_wdata, mem_rdata, wp_stat_wdata;

  always #(CLK_P/2) clk = ~clk;

  spi_mem_slave #(.AW(AW)) i_spi_mem_slave (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .wp_chk_addr(wp_chk_addr),
    .wp_mem_ok(wp_mem_ok), .wp_stat_ok(wp_stat_ok), .wp_status(wp_status),
    .wp_latch_set(wp_latch_set), .wp_latch_clr(wp_latch_clr),
    .wp_stat_wr(wp_stat_wr), .wp_stat_wdata(wp_stat_wdata)
  );

  logic [7:0] ram [DEPTH];
  logic [7:0] exp_mem [DEPTH];
  logic [7:0] rdq;
  logic [AW:0] prot_base;
  assign wp_mem_ok = ({1'b0, wp_chk_addr} < prot_base);
  assign mem_rdata = rdq;
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) rdq <= ram[mem_addr];
  end

  int set_cnt = 0, clr_cnt = 0, swr_cnt = 0, we_cnt = 0, oe_cnt = 0, hi_chg = 0;
  logic [7:0] swr_last = 8'h00;
  logic so_prev = 1'b0, sck_prev = 1'b0;
  always @(posedge clk) begin
    if (!rst) begin
      set_cnt <= set_cnt + int'(wp_latch_set);
      clr_cnt <= clr_cnt + int'(wp_latch_clr);
      we_cnt  <= we_cnt + int'(mem_we);
      oe_cnt  <= oe_cnt + int'(so_oe);
      if (wp_stat_wr) begin swr_cnt <= swr_cnt + 1; swr_last <= wp_stat_wdata; end
      if (sck && sck_prev && so !== so_prev) hi_chg <= hi_chg + 1;
    end
    so_prev <= so; sck_prev <= sck;
  end

  int checks = 0, fails = 0;
  bit done = 0, mode3 = 0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = tx[i]; #HALF;
      rx[i] = so; sck = 1'b1; #HALF;
    end
  endtask

  task automatic xbits(input int n, input logic [7:0] tx);
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; si = tx[i]; #HALF; sck = 1'b1; #HALF;
    end
  endtask

  task automatic cs_on();
    sck = mode3; #HALF; cs_n = 1'b0; #HALF;
  endtask

  task automatic cs_off();
    if (!mode3) begin sck = 1'b0; #HALF; end
    cs_n = 1'b1; #(4*HALF);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    cs_on(); xbyte(op, d); cs_off();
  endtask

  task automatic mem_write(input logic [15:0] a, input int n);
    logic [7:0] d;
    logic [AW-1:0] p;
    cs_on(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int j = 0; j < n; j++) begin
      xbyte(wbuf[j], d);
      p = a[AW-1:0] + AW'(j);
      if ({1'b0, p} < prot_base) exp_mem[p] = wbuf[j];
    end
    cs_off();
  endtask

  task automatic mem_read(input logic [15:0] a, input int n);
    logic [7:0] d;
    cs_on(); xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int j = 0; j < n; j++) begin
      xbyte(8'($urandom), d); rbuf[j] = d;
    end
    cs_off();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, r0, r1;
    int s0, s1;
    void'($urandom(32'h5EED));
    prot_base = (AW+1)'(DEPTH);
    for (int i = 0; i < DEPTH; i++) begin ram[i] = 8'h00; exp_mem[i] = 8'h00; end
    #(CLK_P * 10);
    chk("R11", "so_oe in reset", 32'(so_oe), 0);
    chk("R11", "mem_we in reset", 32'(mem_we), 0);
    chk("R11", "mem_re in reset", 32'(mem_re), 0);
    rst = 1'b0;
    #(CLK_P * 10);
    chk("R11", "strobes after reset", 32'(set_cnt + clr_cnt + swr_cnt), 0);

    // R7 status read, then no drive on the next byte
    cs_on(); xbyte(8'h05, d); xbyte(8'h00, r0);
    s0 = oe_cnt; xbyte(8'hFF, d); s1 = oe_cnt; cs_off();
    chk("R7", "status byte", 32'(r0), 32'h8C);
    chk("R7", "so_oe after status byte", 32'(s1 - s0), 0);

    // R6 / R1 latch set once, later byte not a command
    s0 = set_cnt;
    cs_on(); xbyte(8'h06, d); xbyte(8'h06, d); cs_off();
    chk("R6", "latch set pulses", 32'(set_cnt - s0), 1);
    s0 = clr_cnt; cmd(8'h04);
    chk("R6", "latch clear after 04h", 32'(clr_cnt - s0), 1);

    // R8 status write granted and refused
    s0 = swr_cnt; s1 = clr_cnt;
    cs_on(); xbyte(8'h01, d); xbyte(8'h3C, d); xbyte(8'hFF, d); cs_off();
    chk("R8", "status write count", 32'(swr_cnt - s0), 1);
    chk("R8", "status write data", 32'(swr_last), 32'h3C);
    chk("R6", "latch clear after 01h", 32'(clr_cnt - s1), 1);
    wp_stat_ok = 1'b0; s0 = swr_cnt;
    cs_on(); xbyte(8'h01, d); xbyte(8'h11, d); cs_off();
    chk("R8", "status write refused", 32'(swr_cnt - s0), 0);
    wp_stat_ok = 1'b1;

    // R3 / R5 write with junk upper address bits
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    s1 = clr_cnt;
    mem_write(16'hE123, 3);
    chk("R3", "ram 0123", 32'(ram[13'h0123]), 32'hA1);
    chk("R5", "ram 0124", 32'(ram[13'h0124]), 32'hB2);
    chk("R5", "ram 0125", 32'(ram[13'h0125]), 32'hC3);
    chk("R6", "latch clear after 02h", 32'(clr_cnt - s1), 1);

    // R5 wrap on write
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    mem_write(16'h1FFE, 4);
    chk("R5", "wrap 1FFE", 32'(ram[13'h1FFE]), 32'h11);
    chk("R5", "wrap 1FFF", 32'(ram[13'h1FFF]), 32'h22);
    chk("R5", "wrap 0000", 32'(ram[13'h0000]), 32'h33);
    chk("R5", "wrap 0001", 32'(ram[13'h0001]), 32'h44);
    chk("R5", "wrap 0002 untouched", 32'(ram[13'h0002]), 32'h00);

    // R5 protection boundary
    prot_base = 14'h1000;
    wbuf[0] = 8'h5A; wbuf[1] = 8'h6B;
    mem_write(16'h0FFF, 2);
    chk("R5", "below limit written", 32'(ram[13'h0FFF]), 32'h5A);
    chk("R5", "protected untouched", 32'(ram[13'h1000]), 32'h00);
    prot_base = (AW+1)'(DEPTH);

    // R4 / R2 read across wrap, both modes
    for (int m = 0; m < 2; m++) begin
      mode3 = m[0];
      mem_read(16'h1FFE, 4);
      chk("R4", "read 1FFE", 32'(rbuf[0]), 32'h11);
      chk("R4", "read 1FFF", 32'(rbuf[1]), 32'h22);
      chk("R4", "read 0000 wrap", 32'(rbuf[2]), 32'h33);
      chk("R2", "read 0001", 32'(rbuf[3]), 32'h44);
    end
    mode3 = 0;

    // R9 partial byte discarded
    wbuf[0] = 8'h77; s0 = we_cnt;
    cs_on(); xbyte(8'h02, d); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h77, d);
    xbits(5, 8'hEE); cs_off();
    exp_mem[13'h0200] = 8'h77;
    chk("R9", "one commit only", 32'(we_cnt - s0), 1);
    chk("R9", "ram 0201 untouched", 32'(ram[13'h0201]), 32'h00);
    chk("R9", "so_oe idle", 32'(so_oe), 0);

    // R1 unknown opcode
    s0 = we_cnt; s1 = oe_cnt;
    r0 = 8'(set_cnt + clr_cnt + swr_cnt);
    cs_on(); xbyte(8'hA5, d); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h10, d); xbyte(8'h55, d);
    xbyte(8'h05, d); cs_off();
    chk("R1", "no write on unknown", 32'(we_cnt - s0), 0);
    chk("R1", "no drive on unknown", 32'(oe_cnt - s1), 0);
    chk("R1", "no strobe on unknown", 32'(8'(set_cnt + clr_cnt + swr_cnt)), 32'(r0));

    // R10 hold in mid read
    cs_on(); xbyte(8'h03, d); xbyte(8'h01, d); xbyte(8'h23, d); xbyte(8'h00, r0);
    for (int i = 7; i >= 5; i--) begin
      sck = 1'b0; si = 1'b0; #HALF; r1[i] = so; sck = 1'b1; #HALF;
    end
    sck = 1'b0; #HALF; hold_n = 1'b0; #HALF;
    s0 = oe_cnt;
    for (int k = 0; k < 3; k++) begin sck = 1'b1; #HALF; sck = 1'b0; #HALF; end
    chk("R10", "so_oe low during hold", 32'(oe_cnt - s0), 0);
    hold_n = 1'b1; #HALF;
    for (int i = 4; i >= 0; i--) begin
      sck = 1'b0; si = 1'b1; #HALF; r1[i] = so; sck = 1'b1; #HALF;
    end
    cs_off();
    chk("R10", "byte before hold", 32'(r0), 32'hA1);
    chk("R10", "byte across hold", 32'(r1), 32'hB2);

    // random writes and read-backs
    for (int k = 0; k < 10; k++) begin
      logic [15:0] a;
      int n;
      mode3 = 1'($urandom);
      a = 16'($urandom);
      n = 1 + int'($urandom % 4);
      prot_base = (AW+1)'($urandom % (DEPTH + 1));
      for (int j = 0; j < n; j++) wbuf[j] = 8'($urandom);
      mem_write(a, n);
      mem_read(a, n);
      for (int j = 0; j < n; j++)
        chk("R5", "random read-back", 32'(rbuf[j]), 32'(exp_mem[a[AW-1:0] + AW'(j)]));
    end
    chk("R2", "so change while sck high", 32'(hi_chg), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule